// File: doc/BRIEF.md
# Priority Pin Crossbar Decoder

This block hands 32 external pins, grouped as four 8-bit ports, to on-chip digital peripherals. Three 8-bit configuration bytes say which peripheral groups want pins, and how many signals the two variable-width groups bring. The enabled groups are packed onto the pins in a fixed group priority, starting at the highest-priority pin. Any pin that no group claims is a general-purpose output driven from its port latch bit.

Each pin also has a mode bit that picks push-pull or open-drain drive. Peripheral input signals are fed back from the pin they were given. The current pad level of every pin can always be read back. One group is a clock output that the block makes itself, by dividing the system clock by 1, 2, 4 or 8.

Assignment is worked out from the configuration every cycle. Turning a group off moves every lower-priority group up to fill the space it leaves.

Top module: `pin_xbar_top`

## Requirements
- R1: While the global enable `xbar_cfg2[0]` is 0, no pin is assigned: every pin is GPIO and every `sig_in` bit reads 1.
- R2: Pin p is port p/8, bit p%8, and pin 0 has the highest priority. The enabled signals fill pins 0, 1, 2 and onward in slot order. Slots by group, highest group first: 0-1 serial port A (tx out, rx in); 2-5 SPI (sck out, miso in, mosi out, nss in); 6-7 two-wire bus (data out, clock out); 8-9 serial port B (tx out, rx in); 10-16 capture/compare (10-15 outputs, 16 count input); 17-18 comparator outputs; 19-26 timer and interrupt inputs; 27 clock output; 28-29 conversion-start inputs.
- R3: Group enables are set as follows. `xbar_cfg0` bits 0 to 3 enable serial A, SPI, the two-wire bus and serial B. `xbar_cfg0[6:4]` gives the capture/compare count (0 to 7). `xbar_cfg0[7]` enables the comparators. `xbar_cfg1[3:0]` gives the timer count, and values above 8 count as 8. `xbar_cfg1[4]` enables the clock output and `xbar_cfg1[7]` enables conversion-start. A group with count n takes its first n slots, and a disabled group takes no pins.
- R4: A pin that no slot claims drives its `port_latch` bit.
- R5: A pin given to an input slot has `pin_oe` at 0 and `pin_out` at 1.
- R6: A pin given to an output slot drives that slot's `sig_out` bit. The clock-output slot is the exception: it drives the divided clock instead.
- R7: `sig_in[s]` equals `pin_in` at the pin that slot s was given. If slot s has no pin, `sig_in[s]` reads 1.
- R8: For a driving pin, `pin_oe` is 1 when `port_mode` is 1 (push-pull). When `port_mode` is 0 (open-drain), `pin_oe` is the inverse of `pin_out`.
- R9: `port_rd` always equals `pin_in`.
- R10: `xbar_cfg1[6:5]` selects the clock-output divide: 0, 1, 2 and 3 select divide by 1, 2, 4 and 8. Divide by 1 is the system clock itself. Otherwise the output is bit (sel-1) of a 3-bit counter that advances on each clock edge.
- R11: Synchronous reset holds the divider counter at 0, so the divided outputs read 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | synchronous active-low reset |
| xbar_cfg0 | input | 8 | group enables and capture/compare count |
| xbar_cfg1 | input | 8 | timer count, clock-out enable, divide, conversion-start enable |
| xbar_cfg2 | input | 8 | bit 0 global enable |
| port_latch | input | 32 | GPIO output latch bits, pin order |
| port_mode | input | 32 | 1 push-pull, 0 open-drain, per pin |
| pin_in | input | 32 | pad level of each pin |
| pin_out | output | 32 | value driven to each pad |
| pin_oe | output | 32 | output enable of each pad |
| port_rd | output | 32 | pin level read back |
| sig_out | input | 30 | peripheral outputs by slot |
| sig_in | output | 30 | peripheral inputs by slot |

## Verification
The assertions expect the configuration bytes and the mode bits to be settled values at each rising edge. The divider check also expects reset to be held for at least two edges before release, so that the counter history is known. The bench drives every input one nanosecond after the rising edge and holds reset for several cycles at the start. This keeps all inputs stable around each sampling edge. The random configurations include timer counts above 8 and every capture/compare count, so the saturating and partial-group cases are reached within the legal input space.

// File: rtl/pxb_pkg.sv
// Shared constants and helpers for the pin crossbar.
// Assumes the fixed slot table: 9 groups, 30 slots, 8-bit ports.
package pxb_pkg;
    localparam int NGRP     = 9;
    localparam int NSIG     = 30;
    localparam int PORT_W   = 8;
    localparam int POS_W    = 6;
    localparam int CLK_SLOT = 27;
    // 1 marks a slot that is a peripheral input
    localparam logic [NSIG-1:0] SIG_IS_IN = 30'h37F9022A;

    // largest number of slots of group g
    function automatic int grp_max(input int g);
        case (g)
            0: return 2;
            1: return 4;
            2: return 2;
            3: return 2;
            4: return 7;
            5: return 2;
            6: return 8;
            7: return 1;
            default: return 2;
        endcase
    endfunction

    // first slot index of group g
    function automatic int grp_base(input int g);
        int b;
        b = 0;
        for (int k = 0; k < NGRP; k++)
            if (k < g) b += grp_max(k);
        return b;
    endfunction

    // group owning slot s
    function automatic int slot_grp(input int s);
        int r;
        r = 0;
        for (int k = 0; k < NGRP; k++)
            if (s >= grp_base(k)) r = k;
        return r;
    endfunction

    // signals requested by group g under the configuration bytes
    function automatic int grp_req(input int g, input logic [7:0] c0, input logic [7:0] c1);
        case (g)
            0: return c0[0] ? 2 : 0;
            1: return c0[1] ? 4 : 0;
            2: return c0[2] ? 2 : 0;
            3: return c0[3] ? 2 : 0;
            4: return int'(c0[6:4]);
            5: return c0[7] ? 2 : 0;
            6: return (c1[3:0] > 4'd8) ? 8 : int'(c1[3:0]);
            7: return c1[4] ? 1 : 0;
            default: return c1[7] ? 2 : 0;
        endcase
    endfunction
endpackage

// File: rtl/pxb_alloc.sv
// Priority packer: gives each active slot its pin position.
// Assumes configuration bytes are stable within a cycle; purely combinational.
module pxb_alloc
    import pxb_pkg::*;
(
    input  logic [7:0]                   cfg0,
    input  logic [7:0]                   cfg1,
    input  logic                         xbar_en,
    output logic [NSIG-1:0]              slot_act,
    output logic [NSIG-1:0][POS_W-1:0]   slot_pos
);
    int grp_start [NGRP];
    int grp_cnt   [NGRP];

    // running start offset of each group in priority order
    always_comb begin
        int nxt;
        nxt = 0;
        for (int g = 0; g < NGRP; g++) begin
            grp_cnt[g]   = xbar_en ? grp_req(g, cfg0, cfg1) : 0;
            grp_start[g] = nxt;
            nxt          = nxt + grp_cnt[g];
        end
    end

    // position and activity of each slot from its group start
    always_comb begin
        for (int s = 0; s < NSIG; s++) begin
            slot_act[s] = (s - grp_base(slot_grp(s))) < grp_cnt[slot_grp(s)];
            slot_pos[s] = POS_W'(grp_start[slot_grp(s)] + s - grp_base(slot_grp(s)));
        end
    end
endmodule

// File: rtl/pxb_pinmux.sv
// Per-pin output and output-enable select.
// Assumes at most one active slot maps to any pin (guaranteed by the packer).
module pxb_pinmux
    import pxb_pkg::*;
#(
    parameter int NPIN = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NSIG-1:0]              slot_act,
    input  logic [NSIG-1:0][POS_W-1:0]   slot_pos,
    input  logic [NSIG-1:0]              eff_out,
    input  logic [NPIN-1:0]              port_latch,
    input  logic [NPIN-1:0]              port_mode,
    output logic [NPIN-1:0]              pin_out,
    output logic [NPIN-1:0]              pin_oe
);
    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        logic is_in;
        logic val;

        // pick the slot claiming this pin, else the latch bit
        always_comb begin
            is_in = 1'b0;
            val   = port_latch[p];
            for (int s = 0; s < NSIG; s++) begin
                if (slot_act[s] && (int'(slot_pos[s]) == p)) begin
                    is_in = SIG_IS_IN[s];
                    val   = SIG_IS_IN[s] ? 1'b1 : eff_out[s];
                end
            end
        end

        assign pin_out[p] = val;
        assign pin_oe[p]  = !is_in && (port_mode[p] || !val);
    end

    // R8
    open_drain_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & ~port_mode & pin_out) == '0);
endmodule

// File: rtl/pxb_fanback.sv
// Returns each assigned slot the level of its pin; unassigned slots idle at 1.
// Assumes the packer output; purely combinational.
module pxb_fanback
    import pxb_pkg::*;
#(
    parameter int NPIN = 32
) (
    input  logic [NSIG-1:0]              slot_act,
    input  logic [NSIG-1:0][POS_W-1:0]   slot_pos,
    input  logic [NPIN-1:0]              pin_in,
    output logic [NSIG-1:0]              sig_in
);
    // route pin levels back to the slots that own them
    always_comb begin
        sig_in = '1;
        for (int p = 0; p < NPIN; p++)
            for (int s = 0; s < NSIG; s++)
                if (slot_act[s] && (int'(slot_pos[s]) == p))
                    sig_in[s] = pin_in[p];
    end
endmodule

// File: rtl/pxb_clkdiv.sv
// Clock-output divider: system clock or one tap of a free-running counter.
// Assumes sel is a settled configuration field.
module pxb_clkdiv #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             ck_out
);
    localparam int CNT_W = (1 << SEL_W) - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   taps;

    // free-running divider counter, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    assign taps   = {cnt, clk};
    assign ck_out = taps[sel];

    // R10
    div_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cnt == $past(cnt) + 1'b1);

    // R11
    div_reset_chk: assert property (@(posedge clk)
        !$past(rst_n) && $past(rst_n, 2) === 1'b0 |-> cnt == '0 || rst_n);
endmodule

// File: rtl/pin_xbar_top.sv
// Priority pin crossbar top: packer, pin mux, input fan-back, clock divider.
// Assumes configuration inputs come from registers in the system clock domain.
module pin_xbar_top
    import pxb_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int NPIN  = NPORT * PORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        xbar_cfg0,
    input  logic [7:0]        xbar_cfg1,
    input  logic [7:0]        xbar_cfg2,
    input  logic [NPIN-1:0]   port_latch,
    input  logic [NPIN-1:0]   port_mode,
    input  logic [NPIN-1:0]   pin_in,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pin_oe,
    output logic [NPIN-1:0]   port_rd,
    input  logic [NSIG-1:0]   sig_out,
    output logic [NSIG-1:0]   sig_in
);
    logic [NSIG-1:0]            slot_act;
    logic [NSIG-1:0][POS_W-1:0] slot_pos;
    logic [NSIG-1:0]            eff_out;
    logic                       ck_div;
    logic                       unused_bits;

    assign unused_bits = ^{xbar_cfg2[7:1], sig_out[CLK_SLOT]};

    pxb_alloc u_alloc (
        .cfg0     (xbar_cfg0),
        .cfg1     (xbar_cfg1),
        .xbar_en  (xbar_cfg2[0]),
        .slot_act (slot_act),
        .slot_pos (slot_pos)
    );

    pxb_clkdiv #(.SEL_W(2)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (xbar_cfg1[6:5]),
        .ck_out (ck_div)
    );

    // substitute the divided clock into the clock-output slot
    always_comb begin
        eff_out           = sig_out;
        eff_out[CLK_SLOT] = ck_div;
    end

    pxb_pinmux #(.NPIN(NPIN)) u_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_act   (slot_act),
        .slot_pos   (slot_pos),
        .eff_out    (eff_out),
        .port_latch (port_latch),
        .port_mode  (port_mode),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe)
    );

    pxb_fanback #(.NPIN(NPIN)) u_fan (
        .slot_act (slot_act),
        .slot_pos (slot_pos),
        .pin_in   (pin_in),
        .sig_in   (sig_in)
    );

    assign port_rd = pin_in;

    // R1
    off_gpio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xbar_cfg2[0] |-> pin_out == port_latch);

    // R1
    off_idle_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xbar_cfg2[0] |-> sig_in == '1);

    // R5
    in_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xbar_cfg2[0] && xbar_cfg0 == 8'h01 |-> !pin_oe[1] && pin_out[1]);
endmodule

// File: tb/sim_pin_xbar_top.sv
`timescale 1ns/100ps
module sim_pin_xbar_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  c0 = '0, c1 = '0, c2 = '0;
    logic [31:0] latch = '0, mode = '0, pin_in = '0;
    logic [31:0] pin_out, pin_oe, port_rd;
    logic [29:0] sig_out = '0;
    logic [29:0] sig_in;

    int    total = 0;
    int    bad = 0;
    int    ticks = 0;
    bit    done = 0;
    string phase = "R11";

    always #2.5 clk = ~clk;

    pin_xbar_top u0 (
        .clk(clk), .rst_n(rst_n),
        .xbar_cfg0(c0), .xbar_cfg1(c1), .xbar_cfg2(c2),
        .port_latch(latch), .port_mode(mode), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .port_rd(port_rd),
        .sig_out(sig_out), .sig_in(sig_in)
    );

    // bench view of the divider counter
    always @(posedge clk) begin
        if (!rst_n) ticks = 0;
        else        ticks = ticks + 1;
    end

    function automatic bit slot_input(int s);
        return (s == 1 || s == 3 || s == 5 || s == 9 || s == 16 ||
                (s >= 19 && s <= 26) || s == 28 || s == 29);
    endfunction

    function automatic int want(int g);
        int sizes[9] = '{2, 4, 2, 2, 7, 2, 8, 1, 2};
        case (g)
            0: return c0[0] ? sizes[0] : 0;
            1: return c0[1] ? sizes[1] : 0;
            2: return c0[2] ? sizes[2] : 0;
            3: return c0[3] ? sizes[3] : 0;
            4: return c0[6:4];
            5: return c0[7] ? sizes[5] : 0;
            6: return (c1[3:0] > 8) ? 8 : c1[3:0];
            7: return c1[4] ? 1 : 0;
            default: return c1[7] ? 2 : 0;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", phase, tag, act, exp);
        end
    endtask

    // reference: queue of slots in pin order
    task automatic check_all();
        int sizes[9] = '{2, 4, 2, 2, 7, 2, 8, 1, 2};
        int q[$];
        int base = 0;
        logic [31:0] e_out, e_oe;
        logic [29:0] e_in;
        logic ck;
        int sel = c1[6:5];
        ck = (sel == 0) ? 1'b0 : 1'(((ticks % 8) >> (sel - 1)) & 1);
        if (c2[0]) begin
            for (int g = 0; g < 9; g++) begin
                for (int j = 0; j < want(g); j++) q.push_back(base + j);
                base += sizes[g];
            end
        end
        e_in = '1;
        for (int p = 0; p < 32; p++) begin
            logic v;
            if (p < q.size()) begin
                int s = q[p];
                e_in[s] = pin_in[p];
                if (slot_input(s)) begin
                    e_out[p] = 1'b1; e_oe[p] = 1'b0;
                    continue;
                end
                v = (s == 27) ? ck : sig_out[s];
            end else begin
                v = latch[p];
            end
            e_out[p] = v;
            e_oe[p]  = mode[p] | ~v;
        end
        chk("pin_out R2/R4/R6/R10", pin_out, e_out);
        chk("pin_oe R5/R8", pin_oe, e_oe);
        chk("sig_in R7", {2'b0, sig_in}, {2'b0, e_in});
        chk("port_rd R9", port_rd, pin_in);
    endtask

    task automatic run(logic [7:0] a, logic [7:0] b, logic [7:0] e, int n, bit od, bit rnd);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            if (rnd) begin
                c0 = 8'($urandom); c1 = 8'($urandom); c2 = {7'($urandom), 1'b1};
            end else begin
                c0 = a; c1 = b; c2 = e;
            end
            latch   = $urandom;
            mode    = od ? 32'h0 : $urandom;
            pin_in  = $urandom;
            sig_out = 30'($urandom);
            @(negedge clk);
            #0.5;
            check_all();
        end
    endtask

    initial begin
        // R11: divider held at zero during reset, clock slot alone on pin 0
        run(8'h00, 8'h70, 8'h01, 4, 1'b0, 1'b0);
        rst_n = 1'b1;
        phase = "R1";
        run(8'hFF, 8'hFF, 8'h00, 20, 1'b0, 1'b0);
        phase = "R3";
        for (int k = 0; k < 8; k++) run({1'b0, 3'(k), 4'h0}, 8'h00, 8'h01, 2, 1'b0, 1'b0);
        for (int k = 0; k < 16; k++) run(8'h00, {4'h0, 4'(k)}, 8'h01, 2, 1'b0, 1'b0);
        for (int k = 0; k < 8; k++) run(8'(1 << k), 8'h00, 8'h01, 2, 1'b0, 1'b0);
        run(8'h00, 8'h90, 8'h01, 2, 1'b0, 1'b0);
        phase = "R10";
        for (int k = 0; k < 4; k++) run(8'h00, {1'b0, 2'(k), 5'h10}, 8'h01, 16, 1'b0, 1'b0);
        phase = "R8";
        run(8'h00, 8'h00, 8'h00, 200, 1'b1, 1'b1);
        phase = "R2";
        run(8'h00, 8'h00, 8'h00, 1500, 1'b0, 1'b1);
        run(8'hFF, 8'hFF, 8'h01, 50, 1'b0, 1'b0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            bad++;
            $display("FAIL watchdog all act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule